// File: doc/BRIEF.md
# Hex Record Parser with Bit Reversal

This block sits on the write path of a serial-flash loader. It takes a stream of ASCII characters, one per valid cycle, that carries a hexadecimal memory image laid out as text records, one record per line. It decodes each record, checks its checksum, and turns each data byte into a byte/address pair for the flash write logic. The bit order of every data byte is reversed on the way out. This is needed because the image assumes LSB-first serialisation, while the flash is read MSB first during configuration.

A record is a colon followed by hex digit pairs: a byte count, a 16-bit offset, a record type, the data bytes and a checksum. Data records (type 00) emit their bytes at consecutive addresses starting at the offset. Extended-address records (type 04) set the upper address bits used by later records. The end-of-file record (type 01) raises a flag that tells the caller that programming is finished. All other record types are parsed and checked, but they produce nothing. Line endings and other text between records are ignored. A malformed record, a failed checksum or an out-of-range address produces a one-cycle error pulse.

Top module: `hexrec_parser`

## Requirements
- R1: Characters received while no record is open (CR 0x0D, LF 0x0A, spaces, letters) produce no output byte and no error. Only a colon (0x3A) opens a record.
- R2: Hex digits 0-9, A-F and a-f are all accepted, and upper and lower case decode to the same value.
- R3: In a type 00 record, data byte k (counting from 0) is emitted with `outAddr` = {upper bits, offset + k}. `outValid` is high for exactly the one cycle after the clock edge that takes in the byte's second digit.
- R4: Each emitted byte is the bit reverse of the record byte: bit i of `outData` equals bit 7-i of the record byte. For example, 0x0C is emitted as 0x30 and 0x55 as 0xAA.
- R5: In a type 04 record, the second data byte becomes address bits 23:16 for all later records, taking effect only when that record's checksum is good. No output byte is produced. After reset the upper bits are zero.
- R6: The 8-bit sum of all bytes of a record, checksum included, must be 0x00. Otherwise `recErr` pulses for one cycle after the edge that takes in the checksum's second digit.
- R7: A good type 01 record (":00000001FF") sets `eofFlag` and emits no byte. `eofFlag` stays high until reset or until the next colon.
- R8: Records of any type other than 00, 01 and 04 produce no output byte. Their checksum is still checked.
- R9: A data byte whose full address exceeds `ADDR_LIMIT` (default 0x1FFFFF) is not emitted, and its record ends with a `recErr` pulse. A byte at exactly `ADDR_LIMIT` is emitted.
- R10: A non-hex character inside an open record pulses `recErr` and closes the record. A colon inside an open record pulses `recErr` and starts a fresh record.
- R11: After reset, `outValid`, `recErr` and `eofFlag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chValid | input | 1 | A character is present on chData this cycle |
| chData | input | 8 | ASCII character |
| outValid | output | 1 | outData/outAddr hold a byte to write |
| outData | output | 8 | Bit-reversed data byte |
| outAddr | output | 24 | Flash byte address of outData |
| recErr | output | 1 | One-cycle pulse on a bad record |
| eofFlag | output | 1 | End-of-file record seen |

## Verification
On every cycle, the assertions check the following:
- Emitted addresses never exceed the limit.
- An output byte only follows an accepted character.
- The error flag is a single-cycle pulse.
- End of file never coincides with a data byte.
- The end-of-file flag stays set until a colon arrives.

The data values, the reversed bit order, the address sequence, checksum acceptance and rejection, the deferred effect of extended-address records, and the treatment of noise and unknown record types depend on whole records. Only the bench's directed scenarios can show these.

// File: rtl/hexrec_pkg.sv
package hexrec_pkg;

  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;

  // Strobes from control to datapath
  typedef struct packed {
    logic storeHi;    // latch high nibble
    logic clrRec;     // start of record: clear checksum
    logic addSum;     // add current byte to checksum
    logic ldOffH;     // load offset high byte
    logic ldOffL;     // load offset low byte
    logic emit;       // present current byte on output
    logic bumpOff;    // advance offset
    logic ldExtPend;  // capture pending upper address
    logic commitExt;  // apply pending upper address
    logic setEof;     // raise end-of-file
    logic clrEof;     // drop end-of-file
    logic errPulse;   // record error
  } hexrec_ctl_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CNT, ST_OFFH, ST_OFFL, ST_TYPE, ST_DATA, ST_CSUM
  } hexrec_state_e;

  localparam logic [7:0] REC_DATA = 8'h00;
  localparam logic [7:0] REC_EOF  = 8'h01;
  localparam logic [7:0] REC_EXT  = 8'h04;
  localparam logic [7:0] CH_COLON = 8'h3A;

  // {valid, value}
  function automatic logic [NIB_W:0] hexDecode(input logic [7:0] c);
    logic [NIB_W:0] r;
    r = '0;
    if (c >= 8'h30 && c <= 8'h39)      r = {1'b1, c[3:0]};
    else if (c >= 8'h41 && c <= 8'h46) r = {1'b1, c[3:0] + 4'd9};
    else if (c >= 8'h61 && c <= 8'h66) r = {1'b1, c[3:0] + 4'd9};
    return r;
  endfunction

endpackage

// File: rtl/hexrec_dp.sv
module hexrec_dp
  import hexrec_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int OFF_W  = 16,
  parameter logic [ADDR_W-1:0] ADDR_LIMIT = 24'h1FFFFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BYTE_W-1:0]  chData,
  input  hexrec_ctl_t        ctl,
  output logic               isHex,
  output logic               isColon,
  output logic [BYTE_W-1:0]  curByte,
  output logic               sumOk,
  output logic               addrOver,
  output logic               outValid,
  output logic [BYTE_W-1:0]  outData,
  output logic [ADDR_W-1:0]  outAddr,
  output logic               recErr,
  output logic               eofFlag
);
  localparam int EXT_W = ADDR_W - OFF_W;

  logic [NIB_W:0]       decoded;
  logic [NIB_W-1:0]     hiNib;
  logic [BYTE_W-1:0]    sumReg;
  logic [BYTE_W-1:0]    sumNext;
  logic [OFF_W-1:0]     offset;
  logic [EXT_W-1:0]     extHi;
  logic [EXT_W-1:0]     extPend;
  logic [BYTE_W-1:0]    revByte;
  logic [ADDR_W-1:0]    curAddr;

  assign decoded = hexDecode(chData);
  assign isHex   = decoded[NIB_W];
  assign isColon = (chData == CH_COLON);
  assign curByte = {hiNib, decoded[NIB_W-1:0]};
  assign sumNext = sumReg + curByte;
  assign sumOk   = (sumNext == '0);
  assign curAddr = {extHi, offset};
  assign addrOver = (curAddr > ADDR_LIMIT);

  for (genvar i = 0; i < BYTE_W; i++) begin : g_rev
    assign revByte[i] = curByte[BYTE_W-1-i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hiNib    <= '0;
      sumReg   <= '0;
      offset   <= '0;
      extHi    <= '0;
      extPend  <= '0;
      outValid <= 1'b0;
      outData  <= '0;
      outAddr  <= '0;
      recErr   <= 1'b0;
      eofFlag  <= 1'b0;
    end else begin
      if (ctl.storeHi) hiNib <= decoded[NIB_W-1:0];
      if (ctl.clrRec)       sumReg <= '0;
      else if (ctl.addSum)  sumReg <= sumNext;
      if (ctl.ldOffH)       offset[OFF_W-1:BYTE_W] <= curByte;
      else if (ctl.ldOffL)  offset[BYTE_W-1:0] <= curByte;
      else if (ctl.bumpOff) offset <= offset + 1'b1;
      if (ctl.ldExtPend) extPend <= curByte[EXT_W-1:0];
      if (ctl.commitExt) extHi <= extPend;
      outValid <= ctl.emit;
      if (ctl.emit) begin
        outData <= revByte;
        outAddr <= curAddr;
      end
      recErr <= ctl.errPulse;
      if (ctl.clrEof)      eofFlag <= 1'b0;
      else if (ctl.setEof) eofFlag <= 1'b1;
    end
  end

endmodule

// File: rtl/hexrec_ctl.sv
module hexrec_ctl
  import hexrec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chValid,
  input  logic              isHex,
  input  logic              isColon,
  input  logic [BYTE_W-1:0] curByte,
  input  logic              sumOk,
  input  logic              addrOver,
  output hexrec_ctl_t       ctl
);
  hexrec_state_e     st, stNext;
  logic              phase, phaseNext;
  logic [BYTE_W-1:0] cnt, typ, idx;
  logic              badPend;
  logic              byteDone, badSet;

  always_comb begin
    ctl       = '0;
    stNext    = st;
    phaseNext = phase;
    byteDone  = 1'b0;
    badSet    = 1'b0;
    if (chValid) begin
      if (isColon) begin
        ctl.clrRec   = 1'b1;
        ctl.clrEof   = 1'b1;
        ctl.errPulse = (st != ST_IDLE);
        stNext       = ST_CNT;
        phaseNext    = 1'b0;
      end else if (st == ST_IDLE) begin
        // outside a record: ignore
      end else if (!isHex) begin
        ctl.errPulse = 1'b1;
        stNext       = ST_IDLE;
        phaseNext    = 1'b0;
      end else if (!phase) begin
        ctl.storeHi = 1'b1;
        phaseNext   = 1'b1;
      end else begin
        phaseNext  = 1'b0;
        byteDone   = 1'b1;
        ctl.addSum = (st != ST_CSUM);
        unique case (st)
          ST_CNT:  stNext = ST_OFFH;
          ST_OFFH: begin ctl.ldOffH = 1'b1; stNext = ST_OFFL; end
          ST_OFFL: begin ctl.ldOffL = 1'b1; stNext = ST_TYPE; end
          ST_TYPE: stNext = (cnt == '0) ? ST_CSUM : ST_DATA;
          ST_DATA: begin
            if (typ == REC_DATA) begin
              if (addrOver) badSet = 1'b1;
              else          ctl.emit = 1'b1;
              ctl.bumpOff = 1'b1;
            end
            if (typ == REC_EXT && idx == 8'd1) ctl.ldExtPend = 1'b1;
            if (idx == cnt - 1'b1) stNext = ST_CSUM;
          end
          ST_CSUM: begin
            if (sumOk && !badPend) begin
              ctl.commitExt = (typ == REC_EXT);
              ctl.setEof    = (typ == REC_EOF);
            end else begin
              ctl.errPulse = 1'b1;
            end
            stNext = ST_IDLE;
          end
          default: stNext = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      phase   <= 1'b0;
      cnt     <= '0;
      typ     <= '0;
      idx     <= '0;
      badPend <= 1'b0;
    end else begin
      st    <= stNext;
      phase <= phaseNext;
      if (byteDone && st == ST_CNT)  cnt <= curByte;
      if (byteDone && st == ST_TYPE) begin
        typ <= curByte;
        idx <= '0;
      end
      if (byteDone && st == ST_DATA) idx <= idx + 1'b1;
      if (ctl.clrRec)  badPend <= 1'b0;
      else if (badSet) badPend <= 1'b1;
    end
  end

endmodule

// File: rtl/hexrec_parser.sv
module hexrec_parser
  import hexrec_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int OFF_W  = 16,
  parameter logic [ADDR_W-1:0] ADDR_LIMIT = 24'h1FFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chValid,
  input  logic [7:0]        chData,
  output logic              outValid,
  output logic [7:0]        outData,
  output logic [ADDR_W-1:0] outAddr,
  output logic              recErr,
  output logic              eofFlag
);
  hexrec_ctl_t       ctl;
  logic              isHex, isColon, sumOk, addrOver;
  logic [BYTE_W-1:0] curByte;

  hexrec_ctl uCtl (
    .clk(clk), .rst_n(rst_n), .chValid(chValid), .isHex(isHex),
    .isColon(isColon), .curByte(curByte), .sumOk(sumOk),
    .addrOver(addrOver), .ctl(ctl)
  );

  hexrec_dp #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .ADDR_LIMIT(ADDR_LIMIT)) uDp (
    .clk(clk), .rst_n(rst_n), .chData(chData), .ctl(ctl),
    .isHex(isHex), .isColon(isColon), .curByte(curByte), .sumOk(sumOk),
    .addrOver(addrOver), .outValid(outValid), .outData(outData),
    .outAddr(outAddr), .recErr(recErr), .eofFlag(eofFlag)
  );

endmodule

// File: rtl/hexrec_chk.sv
module hexrec_chk #(
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-1:0] ADDR_LIMIT = 24'h1FFFFF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chValid,
  input logic [7:0]        chData,
  input logic              outValid,
  input logic [ADDR_W-1:0] outAddr,
  input logic              recErr,
  input logic              eofFlag
);
  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> outAddr <= ADDR_LIMIT);                           // R9
  AST_OUT_AFTER_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> $past(chValid));                                  // R3
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    recErr |=> !recErr);                                           // R6
  AST_EOF_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eofFlag) |-> !outValid && !recErr);                      // R7
  AST_EOF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    eofFlag && !(chValid && chData == 8'h3A) |=> eofFlag);         // R7
endmodule

bind hexrec_parser hexrec_chk #(.ADDR_W(ADDR_W), .ADDR_LIMIT(ADDR_LIMIT)) uChk (
  .clk(clk), .rst_n(rst_n), .chValid(chValid), .chData(chData),
  .outValid(outValid), .outAddr(outAddr), .recErr(recErr), .eofFlag(eofFlag)
);

// File: tb/sim_hexrec_parser.sv
`timescale 1ns/1ps
module sim_hexrec_parser;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chValid = 1'b0;
  logic [7:0]  chData = 8'h00;
  logic        outValid, recErr, eofFlag;
  logic [7:0]  outData;
  logic [23:0] outAddr;

  int nChecks = 0;
  int nFails  = 0;
  int nOut = 0;
  int nErr = 0;
  logic [7:0]  capData [64];
  logic [23:0] capAddr [64];
  logic [7:0]  dBuf [16];

  always #5 clk = ~clk;

  hexrec_parser u0 (
    .clk(clk), .rst_n(rst_n), .chValid(chValid), .chData(chData),
    .outValid(outValid), .outData(outData), .outAddr(outAddr),
    .recErr(recErr), .eofFlag(eofFlag)
  );

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clearCap();
    nOut = 0;
    nErr = 0;
  endtask

  task automatic sendChar(input logic [7:0] c);
    @(negedge clk);
    chValid = 1'b1;
    chData  = c;
    @(negedge clk);
    chValid = 1'b0;
    if (outValid && nOut < 64) begin
      capData[nOut] = outData;
      capAddr[nOut] = outAddr;
      nOut++;
    end
    if (recErr) nErr++;
  endtask

  task automatic sendStr(input string s);
    for (int i = 0; i < s.len(); i++) sendChar(s[i]);
  endtask

  function automatic logic [7:0] nibChar(input logic [3:0] n, input bit lower);
    if (n < 4'd10) return 8'h30 + {4'h0, n};
    return (lower ? 8'h61 : 8'h41) + {4'h0, n} - 8'd10;
  endfunction

  task automatic sendByte(input logic [7:0] b, input bit lower);
    sendChar(nibChar(b[7:4], lower));
    sendChar(nibChar(b[3:0], lower));
  endtask

  task automatic sendRec(input logic [7:0] typ, input logic [15:0] off, input int n,
                         input bit lower, input bit corrupt);
    logic [7:0] sum;
    sum = 8'(n) + off[15:8] + off[7:0] + typ;
    for (int i = 0; i < n; i++) sum = sum + dBuf[i];
    sendChar(8'h3A);
    sendByte(8'(n), lower);
    sendByte(off[15:8], lower);
    sendByte(off[7:0], lower);
    sendByte(typ, lower);
    for (int i = 0; i < n; i++) sendByte(dBuf[i], lower);
    sendByte(8'(-sum) ^ (corrupt ? 8'h01 : 8'h00), lower);
    sendChar(8'h0D);
    sendChar(8'h0A);
  endtask

  task automatic setExt(input logic [7:0] hi, input bit corrupt);
    dBuf[0] = 8'h00;
    dBuf[1] = hi;
    sendRec(8'h04, 16'h0000, 2, 1'b0, corrupt);
  endtask

  task automatic t_reset();
    check("R11 outValid", {31'b0, outValid}, 0);
    check("R11 recErr",   {31'b0, recErr}, 0);
    check("R11 eofFlag",  {31'b0, eofFlag}, 0);
  endtask

  task automatic t_data();
    clearCap();
    for (int i = 0; i < 16; i++) dBuf[i] = 8'(i * 17 + 3);
    dBuf[0] = 8'h0C;
    dBuf[1] = 8'h55;
    sendRec(8'h00, 16'h0000, 16, 1'b0, 1'b0);
    check("R3 count", nOut, 16);
    check("R6 good csum no err", nErr, 0);
    check("R4 0C->30", {24'h0, capData[0]}, 32'h30);
    check("R4 55->AA", {24'h0, capData[1]}, 32'hAA);
    for (int i = 0; i < 16; i++) begin
      check("R3 addr", {8'h0, capAddr[i]}, i);
      check("R4 data", {24'h0, capData[i]}, {24'h0, rev8(dBuf[i])});
    end
    check("R5 upper bits zero after reset", {8'h0, capAddr[15]}, 32'h00000F);
  endtask

  task automatic t_lower();
    clearCap();
    dBuf[0] = 8'hAB; dBuf[1] = 8'hCD; dBuf[2] = 8'hEF;
    sendRec(8'h00, 16'hBEE0, 3, 1'b1, 1'b0);
    check("R2 lower count", nOut, 3);
    check("R2 lower err", nErr, 0);
    check("R2 lower addr", {8'h0, capAddr[2]}, 32'h00BEE2);
    check("R2 lower data", {24'h0, capData[1]}, {24'h0, rev8(8'hCD)});
  endtask

  task automatic t_noise();
    clearCap();
    sendStr("\r\n zz GG 0123 xyz\r\n");
    check("R1 noise no out", nOut, 0);
    check("R1 noise no err", nErr, 0);
  endtask

  task automatic t_ext();
    clearCap();
    setExt(8'h01, 1'b0);
    check("R5 ext no out", nOut, 0);
    check("R5 ext no err", nErr, 0);
    dBuf[0] = 8'h11; dBuf[1] = 8'h22;
    sendRec(8'h00, 16'h1000, 2, 1'b0, 1'b0);
    check("R5 ext addr0", {8'h0, capAddr[0]}, 32'h011000);
    check("R5 ext addr1", {8'h0, capAddr[1]}, 32'h011001);
    clearCap();
    setExt(8'h05, 1'b1);
    check("R5 bad ext err", nErr, 1);
    dBuf[0] = 8'h33;
    sendRec(8'h00, 16'h0040, 1, 1'b0, 1'b0);
    check("R5 bad ext not applied", {8'h0, capAddr[0]}, 32'h010040);
    setExt(8'h00, 1'b0);
  endtask

  task automatic t_csum();
    clearCap();
    dBuf[0] = 8'h5A; dBuf[1] = 8'hA5;
    sendRec(8'h00, 16'h0200, 2, 1'b0, 1'b1);
    check("R6 bad csum err pulse", nErr, 1);
  endtask

  task automatic t_eof();
    clearCap();
    sendStr(":00000001FF\r\n");
    check("R7 eof set", {31'b0, eofFlag}, 1);
    check("R7 eof no out", nOut, 0);
    check("R7 eof no err", nErr, 0);
    sendStr("\r\n");
    check("R7 eof held", {31'b0, eofFlag}, 1);
    sendChar(8'h3A);
    check("R7 eof cleared by colon", {31'b0, eofFlag}, 0);
    sendChar(8'h0D);
  endtask

  task automatic t_other();
    clearCap();
    dBuf[0] = 8'h01; dBuf[1] = 8'h02; dBuf[2] = 8'h03; dBuf[3] = 8'h04;
    sendRec(8'h03, 16'h0000, 4, 1'b0, 1'b0);
    check("R8 other type no out", nOut, 0);
    check("R8 other type no err", nErr, 0);
    sendRec(8'h05, 16'h0000, 4, 1'b0, 1'b1);
    check("R8 other type bad csum", nErr, 1);
  endtask

  task automatic t_range();
    clearCap();
    setExt(8'h20, 1'b0);
    dBuf[0] = 8'h77; dBuf[1] = 8'h88;
    sendRec(8'h00, 16'h0000, 2, 1'b0, 1'b0);
    check("R9 over limit no out", nOut, 0);
    check("R9 over limit err", nErr, 1);
    clearCap();
    setExt(8'h1F, 1'b0);
    dBuf[0] = 8'h01;
    sendRec(8'h00, 16'hFFFF, 1, 1'b0, 1'b0);
    check("R9 at limit out", nOut, 1);
    check("R9 at limit addr", {8'h0, capAddr[0]}, 32'h1FFFFF);
    check("R9 at limit data", {24'h0, capData[0]}, 32'h80);
    setExt(8'h00, 1'b0);
  endtask

  task automatic t_abort();
    clearCap();
    sendStr(":1000\r\n");
    check("R10 non-hex in record", nErr, 1);
    check("R10 non-hex no out", nOut, 0);
    clearCap();
    sendStr(":02000");
    dBuf[0] = 8'h0F;
    sendRec(8'h00, 16'h0300, 1, 1'b0, 1'b0);
    check("R10 colon restart err", nErr, 1);
    check("R10 restart out", nOut, 1);
    check("R10 restart addr", {8'h0, capAddr[0]}, 32'h000300);
    check("R10 restart data", {24'h0, capData[0]}, 32'hF0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_data();
    t_lower();
    t_noise();
    t_ext();
    t_csum();
    t_eof();
    t_other();
    t_range();
    t_abort();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule